// File: doc/BRIEF.md
# PLL Divider Pair Search Engine

This block finds the feedback and reference divider settings for a frequency synthesizer that runs from a 14.31818 MHz crystal. The caller gives a target output frequency in hundredths of a megahertz and pulses a start strobe. The engine limits the target to the synthesizer's usable band. It then works out a power-of-two prescale exponent and tries every allowed pair of dividers, one pair after another. For each pair it measures the absolute distance between the frequency that pair would produce and the target, and keeps the closest pair.

The frequency of a pair is computed in 8-bit fixed point as 938356·(N+8) / (2^k·256·(M+2)), with integer floor division. The target is compared in the same scale, as floor(clamped·256/100). Each candidate is divided with a multi-cycle sequential divider that resolves several quotient bits per clock. When the last pair has been scored, a single-cycle done pulse marks a new packed program word on the output.

Top module: `pll_mn_search`

## Requirements
- R1: While rst_ni is low, busy_o, done_o and word_o are all 0. Pulling rst_ni low in the middle of a search returns them to 0 at once.
- R2: A start with target_i equal to 0 skips the search. In the next cycle done_o is 1, busy_o is 0 and word_o is 0x00E0.
- R3: A start with a nonzero target, taken while idle, raises busy_o in the next cycle. busy_o falls only in the cycle where done_o is 1, and done_o stays high for exactly one cycle.
- R4: A target below 8000 gives the same word as 8000. A target above 15938 gives the same word as 15938.
- R5: The prescale exponent k counts how often the clamped target must be doubled to reach at least 64000. It sits in word_o[7:6] and equals 3 for every nonzero target.
- R6: The word is (k<<6) + M + (N<<8), so M is in bits [5:0] and N in bits [15:8]. The pair (M, N) gives the smallest |ref − floor(938356·(N+8)/(2^k·256·(M+2)))| over M = 2..30 and N = 35..247. The search walks M in the outer loop and N in the inner loop, both ascending. A later pair replaces the kept one only when its error is strictly smaller.
- R7: A start pulse that arrives while busy_o is 1 is ignored. The search in progress finishes with the word for its original target.
- R8: word_o changes only in a cycle where done_o is 1, and holds its value between searches.
- R9: With the default settings, busy_o stays high for exactly 30885 cycles per nonzero search (5 cycles for each of the 6177 pairs).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a search; sampled only while idle |
| target_i | input | 16 | Target frequency in 0.01 MHz units |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse: new result on word_o |
| word_o | output | 16 | Packed program word {N, k, M} |

## Verification
Several properties are checked on every cycle: the handshake (busy rising after a start, falling only together with a one-cycle done pulse), the immediate zero-target result, the word holding between done pulses, and the k, M and N fields staying inside their legal ranges. The assertions cannot show whether the chosen pair really is the first minimum, whether clamping maps out-of-band targets onto the band edges, whether a start during a search is ignored, or how long a search takes. The bench shows these by comparing against a model built from the search formula, for targets at both band edges, one target inside the band and one target outside each edge.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_KICK, ST_WAIT} srch_st_e;

  // number of doublings needed to bring val up to lim
  function automatic int dbl_count(input int val, input int lim);
    int v;
    int c;
    v = val;
    c = 0;
    for (int i = 0; i < 31; i++) begin
      if (v < lim) begin
        v = v * 2;
        c++;
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/pll_srch_prep.sv
module pll_srch_prep #(
  parameter int TW         = 16,
  parameter int RW         = 16,
  parameter int KW         = 2,
  parameter int FREQ_MIN   = 8000,
  parameter int FREQ_MAX   = 15938,
  parameter int DBL_LIMIT  = 64000,
  parameter int K_MAX      = 3,
  parameter int FRAC_SHIFT = 8,
  parameter int HZ_DIV     = 100
) (
  input  logic [TW-1:0] target_i,
  output logic          zero_o,
  output logic [RW-1:0] ref_o,
  output logic [KW-1:0] k_o
);

  logic [TW-1:0] clamped;

  always_comb begin
    if (target_i < TW'(FREQ_MIN))      clamped = TW'(FREQ_MIN);
    else if (target_i > TW'(FREQ_MAX)) clamped = TW'(FREQ_MAX);
    else                               clamped = target_i;
  end

  assign zero_o = (target_i == '0);
  assign ref_o  = RW'((32'(clamped) << FRAC_SHIFT) / 32'(HZ_DIV));

  always_comb begin
    logic [31:0]   t;
    logic [KW-1:0] kk;
    t  = 32'(clamped);
    kk = '0;
    for (int i = 0; i < K_MAX; i++) begin
      if (t < 32'(DBL_LIMIT)) begin
        t  = t << 1;
        kk = kk + 1'b1;
      end
    end
    k_o = kk;
  end

endmodule

// File: rtl/pll_srch_div.sv
module pll_srch_div #(
  parameter int PW  = 17,
  parameter int DVW = 6,
  parameter int BPC = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [PW-1:0]  dividend_i,
  input  logic [DVW-1:0] divisor_i,
  output logic           valid_o,
  output logic [PW-1:0]  quot_o
);

  localparam int IT = (PW + BPC - 1) / BPC;
  localparam int QW = IT * BPC;
  localparam int AW = DVW + 1 + QW;
  localparam int CW = $clog2(IT + 1);

  logic [AW-1:0]  acc_q, acc_nx;
  logic [DVW-1:0] dvs_q;
  logic [CW-1:0]  cnt_q;
  logic           valid_q;

  // restoring division, BPC quotient bits per clock
  always_comb begin
    acc_nx = acc_q;
    for (int b = 0; b < BPC; b++) begin
      acc_nx = acc_nx << 1;
      if (acc_nx[AW-1:QW] >= {1'b0, dvs_q}) begin
        acc_nx[AW-1:QW] = acc_nx[AW-1:QW] - {1'b0, dvs_q};
        acc_nx[0]       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start_i) begin
        acc_q <= AW'(dividend_i);
        dvs_q <= divisor_i;
        cnt_q <= CW'(IT);
      end else if (cnt_q != '0) begin
        acc_q   <= acc_nx;
        cnt_q   <= cnt_q - 1'b1;
        valid_q <= (cnt_q == CW'(1));
      end
    end
  end

  assign valid_o = valid_q;
  assign quot_o  = acc_q[PW-1:0];

endmodule

// File: rtl/pll_mn_search.sv
module pll_mn_search
  import pll_srch_pkg::*;
#(
  parameter int TW             = 16,
  parameter int WW             = 16,
  parameter int REF_MULT       = 938356,
  parameter int FREQ_MIN       = 8000,
  parameter int FREQ_MAX       = 15938,
  parameter int PRESCALE_STEPS = 3,
  parameter int M_MIN          = 2,
  parameter int M_MAX          = 30,
  parameter int N_MIN          = 35,
  parameter int N_MAX          = 247,
  parameter int M_OFS          = 2,
  parameter int N_OFS          = 8,
  parameter int FRAC_SHIFT     = 8,
  parameter int HZ_DIV         = 100,
  parameter int K_LSB          = 6,
  parameter int N_LSB          = 8,
  parameter int ZERO_WORD      = 224,
  parameter int DIV_BPC        = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] target_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [WW-1:0] word_o
);

  localparam int DBL_LIMIT = FREQ_MIN << PRESCALE_STEPS;
  localparam int K_MAX     = dbl_count(FREQ_MIN, DBL_LIMIT);
  localparam int K_MIN     = dbl_count(FREQ_MAX, DBL_LIMIT);
  localparam int KW        = (K_MAX > 0) ? $clog2(K_MAX + 1) : 1;
  localparam int RW        = $clog2(((FREQ_MAX << FRAC_SHIFT) / HZ_DIV) + 1);
  localparam int MW        = $clog2(M_MAX + 1);
  localparam int NW        = $clog2(N_MAX + 1);
  localparam int DVW       = $clog2(M_MAX + M_OFS + 1);
  localparam int PRW       = $clog2(REF_MULT * (N_MAX + N_OFS) + 1);
  localparam int PW        = PRW - FRAC_SHIFT - K_MIN;
  localparam int EW        = ((RW > PW) ? RW : PW) + 1;

  srch_st_e       state_q;
  logic [RW-1:0]  ref_q;
  logic [KW-1:0]  k_q;
  logic [MW-1:0]  m_q, best_m_q;
  logic [NW-1:0]  n_q, best_n_q;
  logic [EW-1:0]  best_err_q;
  logic           done_q;
  logic [WW-1:0]  word_q;

  logic           zero_c;
  logic [RW-1:0]  ref_c;
  logic [KW-1:0]  k_c;

  pll_srch_prep #(
    .TW(TW), .RW(RW), .KW(KW), .FREQ_MIN(FREQ_MIN), .FREQ_MAX(FREQ_MAX),
    .DBL_LIMIT(DBL_LIMIT), .K_MAX(K_MAX), .FRAC_SHIFT(FRAC_SHIFT), .HZ_DIV(HZ_DIV)
  ) u_prep (
    .target_i (target_i),
    .zero_o   (zero_c),
    .ref_o    (ref_c),
    .k_o      (k_c)
  );

  // divide by 2^(k+frac) first, then by (M+ofs): same floor, narrower divider
  logic [PRW-1:0] prod;
  logic [PW-1:0]  dividend;
  logic [DVW-1:0] divisor;
  logic           div_valid;
  logic [PW-1:0]  quot;

  assign prod     = (PRW'(n_q) + PRW'(N_OFS)) * PRW'(REF_MULT);
  assign dividend = PW'(prod >> (FRAC_SHIFT + int'(k_q)));
  assign divisor  = DVW'(m_q) + DVW'(M_OFS);

  pll_srch_div #(.PW(PW), .DVW(DVW), .BPC(DIV_BPC)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (state_q == ST_KICK),
    .dividend_i (dividend),
    .divisor_i  (divisor),
    .valid_o    (div_valid),
    .quot_o     (quot)
  );

  logic [EW-1:0] err;
  logic          take, last_pair;
  logic [MW-1:0] win_m;
  logic [NW-1:0] win_n;
  logic [WW-1:0] packed_word;

  always_comb begin
    if (EW'(ref_q) >= EW'(quot)) err = EW'(ref_q) - EW'(quot);
    else                         err = EW'(quot) - EW'(ref_q);
  end

  assign take        = err < best_err_q;  // strict: first minimum wins
  assign last_pair   = (m_q == MW'(M_MAX)) && (n_q == NW'(N_MAX));
  assign win_m       = take ? m_q : best_m_q;
  assign win_n       = take ? n_q : best_n_q;
  assign packed_word = (WW'(k_q) << K_LSB) + WW'(win_m) + (WW'(win_n) << N_LSB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ref_q      <= '0;
      k_q        <= '0;
      m_q        <= '0;
      n_q        <= '0;
      best_m_q   <= '0;
      best_n_q   <= '0;
      best_err_q <= '1;
      done_q     <= 1'b0;
      word_q     <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (zero_c) begin
              word_q <= WW'(ZERO_WORD);
              done_q <= 1'b1;
            end else begin
              ref_q      <= ref_c;
              k_q        <= k_c;
              m_q        <= MW'(M_MIN);
              n_q        <= NW'(N_MIN);
              best_err_q <= '1;
              state_q    <= ST_KICK;
            end
          end
        end
        ST_KICK: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (div_valid) begin
            if (take) begin
              best_err_q <= err;
              best_m_q   <= m_q;
              best_n_q   <= n_q;
            end
            if (last_pair) begin
              word_q  <= packed_word;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_KICK;
              if (n_q == NW'(N_MAX)) begin
                n_q <= NW'(N_MIN);
                m_q <= m_q + 1'b1;
              end else begin
                n_q <= n_q + 1'b1;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign word_o = word_q;

endmodule

// File: rtl/pll_mn_search_chk.sv
module pll_mn_search_chk #(
  parameter int TW        = 16,
  parameter int WW        = 16,
  parameter int KW        = 2,
  parameter int K_EXP     = 3,
  parameter int K_LSB     = 6,
  parameter int N_LSB     = 8,
  parameter int M_MIN     = 2,
  parameter int M_MAX     = 30,
  parameter int N_MIN     = 35,
  parameter int N_MAX     = 247,
  parameter int ZERO_WORD = 224
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [TW-1:0] target_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [WW-1:0] word_o
);

  localparam int NFW = WW - N_LSB;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R3
  AST_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R3
  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && target_i != '0) |=> busy_o); // R3
  AST_ZERO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && target_i == '0) |=> (done_o && !busy_o && word_o == WW'(ZERO_WORD))); // R2
  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(word_o)); // R8
  AST_K_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(busy_o)) |-> (word_o[K_LSB +: KW] == KW'(K_EXP))); // R5
  AST_FIELD_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(busy_o)) |->
      (word_o[K_LSB-1:0] >= K_LSB'(M_MIN) && word_o[K_LSB-1:0] <= K_LSB'(M_MAX) &&
       word_o[WW-1:N_LSB] >= NFW'(N_MIN) && word_o[WW-1:N_LSB] <= NFW'(N_MAX))); // R6

endmodule

bind pll_mn_search pll_mn_search_chk #(
  .TW(TW), .WW(WW), .KW(KW), .K_EXP(K_MAX), .K_LSB(K_LSB), .N_LSB(N_LSB),
  .M_MIN(M_MIN), .M_MAX(M_MAX), .N_MIN(N_MIN), .N_MAX(N_MAX), .ZERO_WORD(ZERO_WORD)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .target_i (target_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .word_o   (word_o)
);

// File: tb/tb_pll_mn_search.sv
module tb_pll_mn_search;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] target = '0;
  logic        busy, done;
  logic [15:0] word;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    finished = 1'b0;

  localparam int WDOG      = 190000;
  localparam int LAT_EXP   = 30885;
  localparam int N_VEC     = 4;
  // {target applied, in-band target whose word it must equal}
  localparam int VEC_T [N_VEC] = '{8000, 11111, 500, 40000};
  localparam int VEC_E [N_VEC] = '{8000, 11111, 8000, 15938};

  always #2 clk = ~clk;

  pll_mn_search dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .target_i (target),
    .busy_o   (busy),
    .done_o   (done),
    .word_o   (word)
  );

  function automatic int model_word(input int t);
    longint c, r, best, fo, d;
    int k, bm, bn;
    if (t == 0) return 224;
    c = (t < 8000) ? 8000 : ((t > 15938) ? 15938 : t);
    r = (c * 256) / 100;
    k = 0;
    while (c < 64000) begin
      c = c * 2;
      k++;
    end
    best = 64'h7FFF_FFFF_FFFF_FFFF;
    bm = 0;
    bn = 0;
    for (int m = 2; m <= 30; m++) begin
      for (int n = 35; n <= 247; n++) begin
        fo = (longint'(938356) * (n + 8)) / ((longint'(1) << k) * 256 * (m + 2));
        d = (r > fo) ? r - fo : fo - r;
        if (d < best) begin
          best = d;
          bm = m;
          bn = n;
        end
      end
    end
    return (k << 6) + bm + (bn << 8);
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_search(input int t, input int inject, output int w, output int bc);
    @(negedge clk);
    start  = 1'b1;
    target = 16'(t);
    bc = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      if (busy) bc++;
      if (inject >= 0 && bc == 100) begin
        start  = 1'b1;
        target = 16'(inject);
      end
    end while (!done);
    w = int'(word);
    check("R3", "busy low at done", busy, 0);
    @(negedge clk);
    check("R3", "done single cycle", done, 0);
    check("R8", "word held after done", word, w);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG && !finished) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog: actual no done, expected done within %0d cycles", WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int w, bc, exp_w;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", busy, 0);
    check("R1", "done in reset", done, 0);
    check("R1", "word in reset", word, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // zero target
    start  = 1'b1;
    target = 16'd0;
    @(negedge clk);
    start = 1'b0;
    check("R2", "zero done", done, 1);
    check("R2", "zero busy", busy, 0);
    check("R2", "zero word", word, 224);
    @(negedge clk);
    check("R2", "zero done pulse end", done, 0);
    target = 16'd12000;
    repeat (5) @(negedge clk);
    check("R8", "word holds without start", word, 224);

    // vector table
    for (int i = 0; i < N_VEC; i++) begin
      exp_w = model_word(VEC_E[i]);
      run_search(VEC_T[i], -1, w, bc);
      if (VEC_T[i] != VEC_E[i]) check("R4", "clamped target word", w, exp_w);
      else                      check("R6", "search word", w, exp_w);
      check("R5", "k field", (w >> 6) & 3, 3);
      check("R9", "busy cycles", bc, LAT_EXP);
    end

    // start while busy is ignored
    exp_w = model_word(15938);
    run_search(15938, 9000, w, bc);
    check("R7", "word after ignored start", w, exp_w);
    check("R7", "busy cycles with ignored start", bc, LAT_EXP);

    // reset mid-search
    @(negedge clk);
    start  = 1'b1;
    target = 16'd11111;
    @(negedge clk);
    start = 1'b0;
    check("R3", "busy after start", busy, 1);
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "busy after async reset", busy, 0);
    check("R1", "word after async reset", word, 0);
    check("R1", "done after async reset", done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "stays idle after reset", busy, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule